// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block sits between a synchronous host and an asynchronous 64K x 16 static RAM. It takes single-beat read and write requests on a valid/ready port. It turns each request into a timed sequence on the memory's active-low strobes: chip select, write enable, output enable and one select per byte lane. It also drives a 16-bit address and a 16-bit data bus, with a separate drive-enable for the pad ring outside the block.

Every phase is counted in clock cycles. The phase lengths come from parameters. Each length is raised to the count that the memory's nanosecond minima need at the configured clock period, and no phase is shorter than one cycle.

A write drives the address and data during a setup phase, then pulls write enable low for the pulse phase. Output enable stays high for the whole write, so the shorter write pulse applies. A read holds chip select and output enable low for the access phase and samples the bus on its last cycle. Byte lanes that the mask leaves out come back as zero. After each read, a turnaround phase with every strobe high lets the memory release the bus before the controller can drive it again.

Top module: `sram_byte_ctrl`

## Requirements
- R1: While reset is asserted, and in every idle cycle, the controller sets `mem_cs_no`, `mem_we_no` and `mem_oe_no` high and every bit of `mem_bs_no` high. It sets `mem_dq_oe_o` low and `req_ready_o` high.
- R2: An accepted write holds chip select low for exactly SET_LEN setup cycles, with write enable high and data driven, followed by WP_LEN pulse cycles with write enable low. The controller then returns to idle.
- R3: Output enable is high in every cycle where write enable is low or the data bus is driven.
- R4: During an access, `mem_bs_no[0]` (bits 7:0) is low exactly when `req_mask_i[0]` was set at acceptance, and `mem_bs_no[1]` (bits 15:8) is low exactly when `req_mask_i[1]` was set. Outside an access, both are high.
- R5: An accepted read holds chip select and output enable low, with write enable high and the bus undriven, for exactly ACC_LEN cycles.
- R6: `rsp_valid_o` is high for exactly one cycle, the cycle after the last read access cycle. `rsp_rdata_o` then carries the bus value sampled on that last cycle, with the bytes whose mask bit was clear forced to zero.
- R7: After a read, the controller spends TURN_LEN cycles with every strobe high, the bus undriven and `req_ready_o` low before it can accept another request.
- R8: `mem_addr_o`, and the write data on `mem_dq_o` during a write, equal the values captured at acceptance and stay constant while chip select is low, whatever the host port does in the meantime.
- R9: `req_ready_o` is low in every busy cycle. A request is taken only on a rising edge where `req_valid_i` and `req_ready_o` are both high, so back-to-back requests start on the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mask_i | input | 2 | Byte lanes: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_addr_i | input | 16 | Word address |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata_o | output | 16 | Read data, unselected bytes zero |
| mem_addr_o | output | 16 | Memory address |
| mem_cs_no | output | 1 | Chip select, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_bs_no | output | 2 | Byte selects, active low, bit 0 = lower byte |
| mem_dq_o | output | 16 | Data to drive onto the bus |
| mem_dq_oe_o | output | 1 | Drive-enable for the data bus |
| mem_dq_i | input | 16 | Data sampled from the bus |

## Verification
The properties assume that reset is held for at least one clock edge. They also assume that the memory never needs more time than the configured phase lengths provide, since the block cannot see the memory's real delays.

The stimulus follows the host handshake. It changes the request fields only on falling edges, and it scrambles them while the controller is busy so that the properties on address and data stability are exercised. The bench's memory model drives the bus only while both chip select and output enable are low. It fills unselected lanes with a fixed non-zero pattern so that the masking of read data can be seen.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_RACC,
    ST_TURN
  } st_e;

  function automatic int cdiv(int a, int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= len_i - CW'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - CW'(1);
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DW = 16,
  localparam int NB = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_i,
  input  logic [NB-1:0] mask_i,
  input  logic [DW-1:0] dq_i,
  output logic          valid_o,
  output logic [DW-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= sample_i;
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       rdata_o[b*8 +: 8] <= '0;
      else if (sample_i) rdata_o[b*8 +: 8] <= mask_i[b] ? dq_i[b*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int AW            = 16,
  parameter int DW            = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int SETUP_CYC     = 1,
  parameter int PULSE_CYC     = 1,
  parameter int ACCESS_CYC    = 2,
  parameter int TURN_CYC      = 1,
  parameter int T_WP_NS       = 7,
  parameter int T_AA_NS       = 10,
  parameter int T_OHZ_NS      = 5,
  localparam int NB           = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [NB-1:0] req_mask_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_cs_no,
  output logic          mem_we_no,
  output logic          mem_oe_no,
  output logic [NB-1:0] mem_bs_no,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  // phase lengths raised to the nanosecond minima, never below one cycle
  localparam int SET_LEN  = imax(SETUP_CYC, 1);
  localparam int WP_LEN   = imax(imax(PULSE_CYC, 1), cdiv(T_WP_NS, CLK_PERIOD_NS));
  localparam int ACC_LEN  = imax(imax(ACCESS_CYC, 1), cdiv(T_AA_NS, CLK_PERIOD_NS));
  localparam int TURN_LEN = imax(imax(TURN_CYC, 1), cdiv(T_OHZ_NS, CLK_PERIOD_NS));
  localparam int MAX_LEN  = imax(imax(SET_LEN, WP_LEN), imax(ACC_LEN, TURN_LEN));
  localparam int CW       = $clog2(MAX_LEN + 1);

  st_e           st_q, st_d;
  logic          load;
  logic [CW-1:0] load_len;
  logic          last;
  logic          accept;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [NB-1:0] mask_q;

  assign accept = req_valid_i && (st_q == ST_IDLE);

  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    load_len = CW'(1);
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        load = 1'b1;
        if (req_write_i) begin st_d = ST_WSET; load_len = CW'(SET_LEN); end
        else             begin st_d = ST_RACC; load_len = CW'(ACC_LEN); end
      end
      ST_WSET: if (last) begin st_d = ST_WPUL; load = 1'b1; load_len = CW'(WP_LEN); end
      ST_WPUL: if (last) st_d = ST_IDLE;
      ST_RACC: if (last) begin st_d = ST_TURN; load = 1'b1; load_len = CW'(TURN_LEN); end
      ST_TURN: if (last) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      mask_q  <= req_mask_i;
    end
  end

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .len_i  (load_len),
    .last_o (last)
  );

  sram_rd_capture #(.DW(DW)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i ((st_q == ST_RACC) && last),
    .mask_i   (mask_q),
    .dq_i     (mem_dq_i),
    .valid_o  (rsp_valid_o),
    .rdata_o  (rsp_rdata_o)
  );

  logic in_access;
  assign in_access   = (st_q == ST_WSET) || (st_q == ST_WPUL) || (st_q == ST_RACC);
  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_cs_no   = !in_access;
  assign mem_we_no   = (st_q != ST_WPUL);
  assign mem_oe_no   = (st_q != ST_RACC);
  assign mem_bs_no   = in_access ? ~mask_q : '1;
  assign mem_dq_oe_o = (st_q == ST_WSET) || (st_q == ST_WPUL);
  assign mem_dq_o    = wdata_q;
  assign mem_addr_o  = addr_q;
endmodule

// File: rtl/sram_byte_ctrl_chk.sv
module sram_byte_ctrl_chk #(
  parameter int AW = 16,
  parameter int NB = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_cs_no,
  input logic          mem_we_no,
  input logic          mem_oe_no,
  input logic [NB-1:0] mem_bs_no,
  input logic          mem_dq_oe_o
);
  // R3
  we_oe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_oe_no);
  // R3
  drive_oe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);
  // R7
  turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |=> !mem_dq_oe_o);
  // R4
  deselect_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cs_no |-> (mem_bs_no == '1) && mem_we_no && mem_oe_no);
  // R2
  pulse_has_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> !mem_cs_no && mem_dq_oe_o);
  // R2
  setup_before_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> $past(mem_dq_oe_o) && $past(!mem_cs_no));
  // R5
  read_strobes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_cs_no && mem_we_no && !mem_dq_oe_o);
  // R8
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && $past(!mem_cs_no)) |-> $stable(mem_addr_o));
  // R6
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R9
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cs_no |-> !req_ready_o);
endmodule

bind sram_byte_ctrl sram_byte_ctrl_chk #(.AW(AW), .NB(NB)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .mem_addr_o  (mem_addr_o),
  .mem_cs_no   (mem_cs_no),
  .mem_we_no   (mem_we_no),
  .mem_oe_no   (mem_oe_no),
  .mem_bs_no   (mem_bs_no),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sim_sram_byte_ctrl.sv
module sim_sram_byte_ctrl;
  localparam int S = 2, W = 2, A = 3, T = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [1:0]  req_mask_i = '0;
  logic [15:0] req_addr_i = '0, req_wdata_i = '0;
  logic        req_ready_o, rsp_valid_o;
  logic [15:0] rsp_rdata_o, mem_addr_o, mem_dq_o;
  logic        mem_cs_no, mem_we_no, mem_oe_no, mem_dq_oe_o;
  logic [1:0]  mem_bs_no;
  logic [15:0] mem_dq_i = 16'hA5A5;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  sram_byte_ctrl #(.SETUP_CYC(S), .PULSE_CYC(W), .ACCESS_CYC(A), .TURN_CYC(T)) u0 (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model
  logic [15:0] ref_mem [int];
  logic [15:0] bus_mem [int];
  int          kind = 0, t = 0;
  bit          acc_evt = 0;
  logic [15:0] m_addr, m_data;
  logic [1:0]  m_mask;

  function automatic logic [15:0] rd(logic [15:0] a, bit bus);
    if (bus) return bus_mem.exists(int'(a)) ? bus_mem[int'(a)] : 16'h0000;
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
  endfunction

  function automatic logic [15:0] lanes(logic [1:0] m, logic [15:0] d, logic [15:0] fill);
    return {m[1] ? d[15:8] : fill[15:8], m[0] ? d[7:0] : fill[7:0]};
  endfunction

  always @(posedge clk_i) begin
    acc_evt = 0;
    if (!rst_ni) begin kind = 0; t = 0; end
    else if (kind == 0) begin
      if (req_valid_i) begin
        kind = req_write_i ? 1 : 2; t = 0; acc_evt = 1;
        m_addr = req_addr_i; m_data = req_wdata_i; m_mask = req_mask_i;
        if (req_write_i) ref_mem[int'(m_addr)] = lanes(m_mask, m_data, rd(m_addr, 0));
      end
    end else begin
      t++;
      if (kind == 1 && t == S + W) kind = 0;
      if (kind == 2 && t == A + T) kind = 0;
    end
  end

  // memory model: writes on the pulse, drives the bus only when selected for read
  always @(negedge clk_i) begin
    if (!mem_cs_no && !mem_we_no)
      bus_mem[int'(mem_addr_o)] = lanes(~mem_bs_no, mem_dq_o, rd(mem_addr_o, 1));
    if (!mem_cs_no && !mem_oe_no) mem_dq_i = lanes(~mem_bs_no, rd(mem_addr_o, 1), 16'hA5A5);
    else                          mem_dq_i = 16'hA5A5;
  end

  // compare every cycle
  always @(negedge clk_i) begin
    bit e_cs, e_we, e_oe, e_drv, e_rdy, e_rv;
    logic [1:0] e_bs;
    string ph;
    e_cs = 1; e_we = 1; e_oe = 1; e_drv = 0; e_rdy = 1; e_rv = 0; e_bs = 2'b11;
    ph = "R1";
    if (rst_ni && kind == 1) begin
      e_cs = 0; e_rdy = 0; e_drv = 1; e_bs = ~m_mask; e_we = (t < S); ph = "R2";
    end else if (rst_ni && kind == 2) begin
      e_rdy = 0;
      if (t < A) begin e_cs = 0; e_oe = 0; e_bs = ~m_mask; ph = "R5"; end
      else ph = "R7";
      e_rv = (t == A);
    end
    chk(mem_cs_no == e_cs, {ph, " cs"}, mem_cs_no, e_cs);
    chk(mem_we_no == e_we, {ph, " we"}, mem_we_no, e_we);
    chk(mem_oe_no == e_oe, "R3 oe", mem_oe_no, e_oe);
    chk(mem_bs_no == e_bs, "R4 byte selects", mem_bs_no, e_bs);
    chk(mem_dq_oe_o == e_drv, {ph, " drive"}, mem_dq_oe_o, e_drv);
    chk(req_ready_o == e_rdy, "R9 ready", req_ready_o, e_rdy);
    chk(rsp_valid_o == e_rv, "R6 rsp_valid", rsp_valid_o, e_rv);
    if (rst_ni && !e_cs) chk(mem_addr_o == m_addr, "R8 addr", mem_addr_o, m_addr);
    if (rst_ni && e_drv) chk(mem_dq_o == m_data, "R8 wdata", mem_dq_o, m_data);
    if (rst_ni && e_rv) begin
      logic [15:0] ex;
      ex = lanes(m_mask, rd(m_addr, 0), 16'h0000);
      chk(rsp_rdata_o == ex, "R6 rdata", rsp_rdata_o, ex);
    end
  end

  task automatic req(bit w, logic [1:0] m, logic [15:0] a, logic [15:0] d);
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = w; req_mask_i = m; req_addr_i = a; req_wdata_i = d;
    do begin @(posedge clk_i); #1; end while (!acc_evt);
    // scramble the host port while busy: must not reach the memory (R8)
    req_valid_i = 0; req_write_i = ~w; req_mask_i = ~m; req_addr_i = ~a; req_wdata_i = ~d;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
    req_valid_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    idle(2);
    req(1, 2'b11, 16'h0000, 16'h1234);
    req(1, 2'b11, 16'hFFFF, 16'hBEEF);          // back-to-back, top address
    req(0, 2'b11, 16'h0000, 16'h0);
    req(1, 2'b11, 16'h0040, 16'hCAFE);          // write right after read turnaround
    req(0, 2'b11, 16'hFFFF, 16'h0);
    idle(3);
    req(1, 2'b01, 16'h0040, 16'h5511);          // lower lane only
    req(1, 2'b10, 16'h0041, 16'h77EE);          // upper lane of a fresh word
    req(0, 2'b11, 16'h0040, 16'h0);
    req(0, 2'b01, 16'h0041, 16'h0);             // lower lane only -> zero
    req(0, 2'b10, 16'h0041, 16'h0);
    req(0, 2'b00, 16'h0040, 16'h0);             // no lanes -> zero
    req(1, 2'b00, 16'h0040, 16'hFFFF);          // write with no lanes: no change
    req(0, 2'b11, 16'h0040, 16'h0);
    for (int i = 0; i < 20; i++) req(1, 2'(i % 4), 16'(i * 977), 16'(i * 40503));
    for (int i = 0; i < 20; i++) req(0, 2'(3 - i % 4), 16'(i * 977), 16'h0);
    idle(10);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule